// File: doc/BRIEF.md
# UART receive status buffer

This block sits between a UART receiver that has already assembled a byte and the host bus. It stores incoming bytes and reports two line status flags: data ready and overrun error. It has two storage modes. In single-register mode one holding register takes each byte. In FIFO mode a 16-entry queue holds the bytes in arrival order. The `fifo_en` input selects the mode. A change of mode discards everything stored.

Occupancy is tracked by a four-state controller:
- `S_EMPTY`: nothing held.
- `S_HOLD`: single-register mode with one byte held.
- `S_PART`: FIFO mode, partly filled.
- `S_FULL`: FIFO mode with every entry used.

The transitions are:
- push: `S_EMPTY` goes to `S_HOLD` or `S_PART`; `S_PART` goes to `S_FULL` when the last free entry is taken.
- pop: `S_HOLD` goes to `S_EMPTY`; `S_FULL` goes to `S_PART`; `S_PART` goes to `S_EMPTY` when the last byte leaves.
- flush: any state goes to `S_EMPTY` when the mode changes.

In every other case the state holds.

A separate path builds a modem status word from the active-low carrier-detect and ring-indicator pins. Both pins pass through a two-flop synchroniser and are then inverted. With loopback enabled, the two bits are taken from two modem control bits instead of the pins.

Top module: `uart_rx_status`

## Requirements
- R1: While reset is held, and on the first sample after it, `lsr_o` and `msr_o` read 0 when both modem pins are high and `mcr_i` is 0.
- R2: `lsr_o[0]` (data ready) is 1 exactly when an unread byte is held. In single-register mode a `rd_rbr` pulse with no new byte in the same cycle clears it on the next cycle.
- R3: In single-register mode, a byte that arrives while a byte is held and no `rd_rbr` occurs in that cycle replaces the held byte and sets `lsr_o[1]` (overrun) on the next cycle. A byte that arrives together with a `rd_rbr` is stored with no overrun.
- R4: In FIFO mode, `rbr_o` shows the oldest unread byte, and bytes leave in the order they arrived, for up to 16 entries.
- R5: In FIFO mode, a byte that arrives while 16 bytes are held and no `rd_rbr` occurs in that cycle is discarded. The stored bytes are unchanged and `lsr_o[1]` is set.
- R6: `lsr_o[1]` clears on the cycle after a `rd_lsr` pulse, unless an overrun event happens in the same cycle as that pulse. In that case the flag stays 1.
- R7: In FIFO mode, `lsr_o[0]` stays 1 while any byte remains and falls only on the cycle after the last byte is read.
- R8: When `fifo_en` differs from the mode in use, all stored bytes are discarded, including a byte arriving in that cycle. `lsr_o[0]` is 0 on the next cycle, and `lsr_o[1]` is not changed.
- R9: With `mcr_i[4]` = 0, `msr_o[7]` equals the inverse of `dcd_n` and `msr_o[6]` equals the inverse of `ri_n`, two clock edges after a pin changes.
- R10: With `mcr_i[4]` = 1, `msr_o[7]` equals `mcr_i[3]` and `msr_o[6]` equals `mcr_i[2]`, in the same cycle, whatever the pins are.
- R11: `msr_o[15:8]`, `msr_o[5:0]` and `lsr_o[7:2]` always read 0.
- R12: A `rd_rbr` pulse while nothing is held has no effect: data ready stays 0, and the next stored byte is read back correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_en | input | 1 | 1 selects FIFO mode, 0 selects single-register mode |
| rx_valid | input | 1 | One-cycle strobe: a received byte is on `rx_data` |
| rx_data | input | 8 | Received byte |
| rd_rbr | input | 1 | Host read strobe for the receive data; pops one byte |
| rd_lsr | input | 1 | Host read strobe for the line status word; clears overrun |
| mcr_i | input | 3 | Modem control bits [4:2]: loopback, out2, out1 |
| dcd_n | input | 1 | Carrier detect pin, active low, asynchronous |
| ri_n | input | 1 | Ring indicator pin, active low, asynchronous |
| rbr_o | output | 8 | Oldest unread byte (valid when `lsr_o[0]` = 1) |
| lsr_o | output | 8 | Line status: bit 1 overrun, bit 0 data ready |
| msr_o | output | 16 | Modem status: bit 7 carrier detect, bit 6 ring indicator |

## Verification
The assertions check the following on every cycle:
- the reserved bits are zero;
- the loopback routing holds;
- overrun is set after every overrun event;
- overrun never rises without such an event;
- a status read without a coinciding event clears overrun;
- a flush empties the buffer;
- a dropped byte in a full FIFO leaves the state and the head byte unchanged.

Only the bench scenarios can show the following:
- the FIFO returns its contents in arrival order;
- the overwritten holding value is the newest byte;
- the byte dropped at full is really gone;
- the two-edge synchroniser latency.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

    typedef enum logic [1:0] {
        S_EMPTY = 2'd0,
        S_HOLD  = 2'd1,
        S_PART  = 2'd2,
        S_FULL  = 2'd3
    } rxs_state_e;

    localparam int LSR_DR_BIT   = 0;
    localparam int LSR_OE_BIT   = 1;
    localparam int MSR_CD_BIT   = 7;
    localparam int MSR_RI_BIT   = 6;
    localparam int MCR_LOOP_BIT = 4;
    localparam int MCR_OUT2_BIT = 3;
    localparam int MCR_OUT1_BIT = 2;

endpackage

// File: rtl/rxs_sync.sv
module rxs_sync #(
    parameter int          W       = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q[i] <= RST_VAL[i];
                sync_q[i] <= RST_VAL[i];
            end else begin
                meta_q[i] <= d_i[i];
                sync_q[i] <= meta_q[i];
            end
        end
    end

    assign q_o = sync_q;

endmodule

// File: rtl/rxs_store.sv
module rxs_store #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic          ovw_en,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] head_o,
    output logic [CW-1:0] count_o
);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [CW-1:0] count;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_en) wr_ptr <= bump(wr_ptr);
            if (rd_en) rd_ptr <= bump(rd_ptr);
            unique case ({wr_en, rd_en})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && !flush)       mem[wr_ptr] <= din;
        else if (ovw_en && !flush) mem[rd_ptr] <= din;
    end

    assign head_o  = mem[rd_ptr];
    assign count_o = count;

endmodule

// File: rtl/rxs_ctrl.sv
module rxs_ctrl
    import rxs_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic          push,
    input  logic          pop,
    input  logic [CW-1:0] count,
    output rxs_state_e    st_o,
    output logic          mode_o,
    output logic          flush_o,
    output logic          wr_en,
    output logic          rd_en,
    output logic          ovw_en,
    output logic          ovr_evt
);

    rxs_state_e st_q, st_d;
    logic       mode_q;
    logic       flush;

    assign flush = (fifo_en != mode_q);

    // next-state logic
    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d = S_EMPTY;
        end else begin
            unique case (st_q)
                S_EMPTY: if (push) st_d = mode_q ? S_PART : S_HOLD;
                S_HOLD:  if (pop && !push) st_d = S_EMPTY;
                S_PART: begin
                    if (push && !pop && count == CW'(DEPTH - 1)) st_d = S_FULL;
                    else if (pop && !push && count == CW'(1))    st_d = S_EMPTY;
                end
                S_FULL:  if (pop && !push) st_d = S_PART;
                default: st_d = S_EMPTY;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= S_EMPTY;
            mode_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            mode_q <= fifo_en;
        end
    end

    // outputs
    always_comb begin
        wr_en   = 1'b0;
        rd_en   = 1'b0;
        ovw_en  = 1'b0;
        ovr_evt = 1'b0;
        if (!flush) begin
            unique case (st_q)
                S_EMPTY: wr_en = push;
                S_PART: begin
                    wr_en = push;
                    rd_en = pop;
                end
                S_HOLD: begin
                    rd_en   = pop;
                    wr_en   = push && pop;
                    ovw_en  = push && !pop;
                    ovr_evt = push && !pop;
                end
                S_FULL: begin
                    rd_en   = pop;
                    wr_en   = push && pop;
                    ovr_evt = push && !pop;
                end
                default: ;
            endcase
        end
    end

    assign st_o    = st_q;
    assign mode_o  = mode_q;
    assign flush_o = flush;

endmodule

// File: rtl/rxs_modem.sv
module rxs_modem
    import rxs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        dcd_n,
    input  logic        ri_n,
    input  logic [4:2]  mcr_i,
    output logic [15:0] msr_o
);

    logic [1:0] pins_s;

    rxs_sync #(.W(2), .RST_VAL(2'b11)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({dcd_n, ri_n}),
        .q_o   (pins_s)
    );

    always_comb begin
        msr_o = '0;
        if (mcr_i[MCR_LOOP_BIT]) begin
            msr_o[MSR_CD_BIT] = mcr_i[MCR_OUT2_BIT];
            msr_o[MSR_RI_BIT] = mcr_i[MCR_OUT1_BIT];
        end else begin
            msr_o[MSR_CD_BIT] = ~pins_s[1];
            msr_o[MSR_RI_BIT] = ~pins_s[0];
        end
    end

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
    import rxs_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_data,
    input  logic          rd_rbr,
    input  logic          rd_lsr,
    input  logic [4:2]    mcr_i,
    input  logic          dcd_n,
    input  logic          ri_n,
    output logic [DW-1:0] rbr_o,
    output logic [7:0]    lsr_o,
    output logic [15:0]   msr_o
);

    localparam int CW = $clog2(DEPTH) + 1;

    rxs_state_e    st;
    logic          mode_q;
    logic          flush;
    logic          wr_en, rd_en, ovw_en, ovr_evt;
    logic [CW-1:0] cnt;
    logic          oe_q;

    rxs_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .fifo_en (fifo_en),
        .push    (rx_valid),
        .pop     (rd_rbr),
        .count   (cnt),
        .st_o    (st),
        .mode_o  (mode_q),
        .flush_o (flush),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .ovw_en  (ovw_en),
        .ovr_evt (ovr_evt)
    );

    rxs_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .ovw_en  (ovw_en),
        .din     (rx_data),
        .head_o  (rbr_o),
        .count_o (cnt)
    );

    rxs_modem u_modem (
        .clk   (clk),
        .rst_n (rst_n),
        .dcd_n (dcd_n),
        .ri_n  (ri_n),
        .mcr_i (mcr_i),
        .msr_o (msr_o)
    );

    // overrun flag: an event in the same cycle beats the clearing read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       oe_q <= 1'b0;
        else if (ovr_evt) oe_q <= 1'b1;
        else if (rd_lsr)  oe_q <= 1'b0;
    end

    always_comb begin
        lsr_o             = '0;
        lsr_o[LSR_DR_BIT] = (st != S_EMPTY);
        lsr_o[LSR_OE_BIT] = oe_q;
    end

endmodule

// File: rtl/rxs_checks.sv
module rxs_checks
    import rxs_pkg::*;
#(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_valid,
    input logic          rd_rbr,
    input logic          rd_lsr,
    input logic [4:2]    mcr_i,
    input logic [DW-1:0] rbr_o,
    input logic [7:0]    lsr_o,
    input logic [15:0]   msr_o,
    input logic          ovr_evt,
    input logic          flush,
    input logic          mode_q,
    input rxs_state_e    st
);

    p_rsvd_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_o[15:8] == 8'h00) && (msr_o[5:0] == 6'h00) && (lsr_o[7:2] == 6'h00));

    p_loopback_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mcr_i[4] |-> (msr_o[7] == mcr_i[3]) && (msr_o[6] == mcr_i[2]));

    p_oe_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_evt |=> lsr_o[1]);

    p_oe_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lsr_o[1]) |-> $past(ovr_evt));

    p_oe_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lsr && !ovr_evt) |=> !lsr_o[1]);

    p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !lsr_o[0]);

    p_single_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q && !flush && st == S_HOLD && rd_rbr && !rx_valid) |=> !lsr_o[0]);

    p_full_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_FULL && rx_valid && !rd_rbr && !flush)
            |=> (st == S_FULL) && (rbr_o == $past(rbr_o)));

    p_fifo_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q && !flush && st == S_PART && !rd_rbr) |=> lsr_o[0]);

endmodule

bind uart_rx_status rxs_checks #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_valid (rx_valid),
    .rd_rbr   (rd_rbr),
    .rd_lsr   (rd_lsr),
    .mcr_i    (mcr_i),
    .rbr_o    (rbr_o),
    .lsr_o    (lsr_o),
    .msr_o    (msr_o),
    .ovr_evt  (ovr_evt),
    .flush    (flush),
    .mode_q   (mode_q),
    .st       (st)
);

// File: tb/sim_uart_rx_status.sv
module sim_uart_rx_status;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 13;

    // {fifo_en, rx_valid, rd_rbr, rd_lsr, data[7:0], exp_dr, exp_oe, chk_rbr, exp_rbr[7:0]}
    localparam logic [22:0] VEC [NVEC] = '{
        {1'b0, 1'b1, 1'b0, 1'b0, 8'hA5, 1'b1, 1'b0, 1'b1, 8'hA5}, // R2 store
        {1'b0, 1'b1, 1'b0, 1'b0, 8'h3C, 1'b1, 1'b1, 1'b1, 8'h3C}, // R3 overwrite
        {1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 1'b1, 8'h3C}, // R6 clear
        {1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00}, // R2 read
        {1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00}, // R12 empty read
        {1'b0, 1'b1, 1'b0, 1'b0, 8'h11, 1'b1, 1'b0, 1'b1, 8'h11}, // R12 next byte
        {1'b0, 1'b1, 1'b1, 1'b0, 8'h22, 1'b1, 1'b0, 1'b1, 8'h22}, // R3 read+arrive
        {1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00}, // R2
        {1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00}, // R8 mode switch
        {1'b1, 1'b1, 1'b0, 1'b0, 8'h01, 1'b1, 1'b0, 1'b1, 8'h01}, // R4
        {1'b1, 1'b1, 1'b0, 1'b0, 8'h02, 1'b1, 1'b0, 1'b1, 8'h01}, // R4 head kept
        {1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'h02}, // R4 R7
        {1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00}  // R7 empty
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        fifo_en, rx_valid, rd_rbr, rd_lsr, dcd_n, ri_n;
    logic [7:0]  rx_data;
    logic [4:2]  mcr_i;
    logic [7:0]  rbr_o, lsr_o;
    logic [15:0] msr_o;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    uart_rx_status u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .fifo_en  (fifo_en),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .rd_rbr   (rd_rbr),
        .rd_lsr   (rd_lsr),
        .mcr_i    (mcr_i),
        .dcd_n    (dcd_n),
        .ri_n     (ri_n),
        .rbr_o    (rbr_o),
        .lsr_o    (lsr_o),
        .msr_o    (msr_o)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive one cycle of inputs, then wait to the next falling edge to sample
    task automatic cyc(input logic fe, input logic v, input logic rr, input logic rl,
                       input logic [7:0] d);
        fifo_en  = fe;
        rx_valid = v;
        rd_rbr   = rr;
        rd_lsr   = rl;
        rx_data  = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n    = 1'b0;
        fifo_en  = 1'b0;
        rx_valid = 1'b0;
        rd_rbr   = 1'b0;
        rd_lsr   = 1'b0;
        rx_data  = 8'h00;
        mcr_i    = 3'b000;
        dcd_n    = 1'b1;
        ri_n     = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 lsr in reset", {8'h00, lsr_o}, 16'h0000);
        check("R1 msr in reset", msr_o, 16'h0000);
        rst_n = 1'b1;
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
        check("R1 lsr after reset", {8'h00, lsr_o}, 16'h0000);
        check("R1 msr after reset", msr_o, 16'h0000);

        // vector table
        for (int i = 0; i < NVEC; i++) begin
            logic [22:0] v;
            v = VEC[i];
            cyc(v[22], v[21], v[20], v[19], v[18:11]);
            check($sformatf("R2 R3 R4 R6 R7 R8 R12 vec %0d dr", i), {15'h0, lsr_o[0]}, {15'h0, v[10]});
            check($sformatf("R3 R6 vec %0d oe", i), {15'h0, lsr_o[1]}, {15'h0, v[9]});
            if (v[8]) check($sformatf("R3 R4 vec %0d rbr", i), {8'h00, rbr_o}, {8'h00, v[7:0]});
        end

        // fill the FIFO to 16 entries
        for (int i = 0; i < 16; i++) cyc(1'b1, 1'b1, 1'b0, 1'b0, 8'h40 + 8'(i));
        check("R5 full dr", {15'h0, lsr_o[0]}, 16'h0001);
        check("R5 full no oe yet", {15'h0, lsr_o[1]}, 16'h0000);
        // overflow together with a status read: event wins
        cyc(1'b1, 1'b1, 1'b0, 1'b1, 8'hEE);
        check("R5 R6 oe set over read", {15'h0, lsr_o[1]}, 16'h0001);
        check("R5 head kept", {8'h00, rbr_o}, 16'h0040);
        cyc(1'b1, 1'b0, 1'b0, 1'b1, 8'h00);
        check("R6 oe cleared", {15'h0, lsr_o[1]}, 16'h0000);
        for (int i = 0; i < 16; i++) begin
            check($sformatf("R4 R5 order %0d", i), {8'h00, rbr_o}, {8'h00, 8'h40 + 8'(i)});
            check($sformatf("R7 dr before pop %0d", i), {15'h0, lsr_o[0]}, 16'h0001);
            cyc(1'b1, 1'b0, 1'b1, 1'b0, 8'h00);
        end
        check("R5 R7 dropped byte absent", {15'h0, lsr_o[0]}, 16'h0000);

        // mode change with data held and a byte arriving
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 8'h77);
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 8'h78);
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 8'h79);
        check("R8 flushed", {15'h0, lsr_o[0]}, 16'h0000);
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
        check("R8 arriving byte discarded", {15'h0, lsr_o[0]}, 16'h0000);

        // overrun set before a mode change survives it
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 8'h10);
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 8'h20);
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
        check("R8 oe unchanged by flush", {15'h0, lsr_o[1]}, 16'h0001);
        check("R8 dr cleared by flush", {15'h0, lsr_o[0]}, 16'h0000);
        cyc(1'b1, 1'b0, 1'b0, 1'b1, 8'h00);

        // modem pins through the synchroniser
        dcd_n = 1'b0;
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
        check("R9 cd after one edge", {15'h0, msr_o[7]}, 16'h0000);
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
        check("R9 cd after two edges", {15'h0, msr_o[7]}, 16'h0001);
        ri_n = 1'b0;
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
        check("R9 ri asserted", {15'h0, msr_o[6]}, 16'h0001);
        check("R11 msr reserved", msr_o & 16'hFF3F, 16'h0000);
        dcd_n = 1'b1;
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
        check("R9 cd released", {15'h0, msr_o[7]}, 16'h0000);

        // loopback overrides pins (ri_n still low, dcd_n high)
        mcr_i = 3'b110;
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
        check("R10 loop cd=out2", {15'h0, msr_o[7]}, 16'h0001);
        check("R10 loop ri=out1", {15'h0, msr_o[6]}, 16'h0000);
        mcr_i = 3'b101;
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
        check("R10 loop swapped", {14'h0, msr_o[7:6]}, 16'h0001);
        check("R11 msr reserved loop", msr_o & 16'hFF3F, 16'h0000);
        check("R11 lsr reserved", {8'h00, lsr_o & 8'hFC}, 16'h0000);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule